// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM's contents alive. It does so by issuing refresh cycles in which CAS# falls before RAS#, and it shares the strobe pins with a separate access sequencer. After reset it waits out a power-up pause. It then runs a fixed train of wake-up refresh cycles on its own and raises `init_done_o`. Only after that may normal accesses begin.

In normal operation an interval timer adds one owed refresh every `INTERVAL_CYC` clocks. The scheduler raises `req_o` while refreshes are owed. It starts a cycle only when the sequencer answers with `grant_i`. Up to `DEBT_MAX` refreshes may be postponed. At that level `urgent_o` tells the sequencer that refresh must come next. If one more interval elapses with the debt still full, the retention guarantee is lost. `init_done_o` then drops, and the wake-up train is repeated after the next grant. A sleep command turns a granted refresh into self refresh: RAS# is held low until a wake command arrives and a minimum hold has passed. A long precharge follows, and the timer restarts from zero.

The DRAM's internal row counter is not modelled. Addresses and OE# are not driven by this block. WE# is always driven high.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is held and in the first cycle after it, RAS#, CAS# and WE# are high and `busy_o`, `init_done_o`, `req_o` and `urgent_o` are low.
- R2: After reset, no strobe moves for at least `PWRUP_CYC` cycles. Exactly `INIT_CYCLES` refresh cycles then follow without needing `grant_i`, and `init_done_o` rises at the end of the last one.
- R3: In every cycle CAS# is already low for at least `CSR_CYC` clocks when RAS# falls. WE# never leaves high.
- R4: RAS# stays low for at least `RAS_CYC` clocks. CAS# stays low for at least `CHR_CYC` clocks after RAS# falls.
- R5: RAS# is high for at least `RP_CYC` clocks before each fall. While initialized, CAS# does not fall earlier than `RP_CYC` clocks after `grant_i` is asserted.
- R6: `req_o` rises `INTERVAL_CYC` clocks (±2) after `init_done_o` rises. Once initialized, no refresh cycle starts unless `grant_i` was high in the cycle before `busy_o` rises.
- R7: Each granted refresh retires exactly one owed refresh. `req_o` is low whenever none are owed.
- R8: `urgent_o` is high exactly when `DEBT_MAX` refreshes are owed. The owed count never exceeds `DEBT_MAX`.
- R9: If an interval elapses while `DEBT_MAX` are already owed, `init_done_o` falls at once and `req_o` and `urgent_o` stay high. After the next grant, `INIT_CYCLES` refresh cycles run and `init_done_o` rises again.
- R10: When `sleep_i` and `grant_i` are both high with no urgent debt, a refresh cycle starts whose RAS# low time lasts at least `SELF_CYC` clocks. RAS# stays low until `wake_i` (level sensitive) is seen.
- R11: On leaving self refresh, RAS# is high for at least `RPS_CYC` clocks before `busy_o` falls. No refresh is owed afterwards, and `req_o` stays low for the following interval.
- R12: `busy_o` is high over every refresh sequence. Whenever `busy_o` is low, RAS# and CAS# are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant_i | input | 1 | Sequencer is idle and cedes the strobes |
| sleep_i | input | 1 | Request to enter self refresh at the next grant |
| wake_i | input | 1 | Request to leave self refresh (level) |
| req_o | output | 1 | At least one refresh is owed |
| urgent_o | output | 1 | Owed refreshes at limit; refresh has top priority |
| ras_n_o | output | 1 | Row strobe to DRAM, active low |
| cas_n_o | output | 1 | Column strobe to DRAM, active low |
| we_n_o | output | 1 | Write enable to DRAM, held high |
| busy_o | output | 1 | The block owns the strobes |
| init_done_o | output | 1 | Wake-up train complete; accesses allowed |

## Verification
The assertions assume a well-behaved sequencer. It raises `grant_i` only while it drives no strobe of its own, and it starts no access while `busy_o` or a low `init_done_o` says the strobes belong to this block. They also assume `wake_i` is held until `busy_o` falls. The stimulus keeps to these rules. Every input is changed one time unit after a rising edge. Grant is raised only when the bench models an idle sequencer, and it is dropped only after a sequence has finished. Sleep and wake are held as levels across the state they request.

// File: rtl/cbr_sched_pkg.sv
// Package: shared types and helpers for the refresh scheduler.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package cbr_sched_pkg;

    // Phases of one strobe sequence.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_CSR,
        PH_LOW,
        PH_HOLD,
        PH_POST
    } phase_e;

    // Operating modes of the scheduler.
    typedef enum logic [2:0] {
        MD_PWR,
        MD_INIT,
        MD_RUN,
        MD_REF,
        MD_SELF
    } mode_e;

    // Larger of two integers, used to size shared counters.
    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cbr_strobe_seq.sv
// Module: cbr_strobe_seq
// Drives one refresh cycle on RAS#/CAS#:
//   precharge, CAS# setup, RAS# low (CAS# held then released),
//   an optional long self-refresh hold, then trailing precharge.
// Assumes start_i is raised only while busy_o is low, and self_i
// stays steady from start until done_o. Strobes come from flops.
module cbr_strobe_seq
    import cbr_sched_pkg::*;
#(
    parameter int RP_CYC   = 4,
    parameter int CSR_CYC  = 1,
    parameter int RAS_CYC  = 6,
    parameter int CHR_CYC  = 1,
    parameter int SELF_CYC = 10000,
    parameter int RPS_CYC  = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic self_i,
    input  logic wake_i,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic busy_o,
    output logic done_o
);

    localparam int MAXC = max_of(max_of(max_of(RP_CYC, CSR_CYC), max_of(RAS_CYC, CHR_CYC)),
                                 max_of(SELF_CYC, RPS_CYC));
    localparam int CW = $clog2(MAXC + 1);
    localparam logic [CW-1:0] L_RP   = CW'(RP_CYC - 1);
    localparam logic [CW-1:0] L_CSR  = CW'(CSR_CYC - 1);
    localparam logic [CW-1:0] L_RAS  = CW'(RAS_CYC - 1);
    localparam logic [CW-1:0] L_SELF = CW'(SELF_CYC - 1);
    localparam logic [CW-1:0] L_RPS  = CW'(RPS_CYC - 1);
    localparam logic [CW-1:0] CAS_REL = CW'(RAS_CYC - CHR_CYC);
    localparam logic [CW-1:0] ONE    = CW'(1);

    phase_e          st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            ras_q, cas_q;
    logic            ras_d, cas_d;

    // Next phase and phase counter.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            PH_IDLE: begin
                if (start_i) begin
                    st_d  = PH_PRE;
                    cnt_d = L_RP;
                end
            end
            PH_PRE: begin
                if (cnt_q == '0) begin
                    st_d  = PH_CSR;
                    cnt_d = L_CSR;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            PH_CSR: begin
                if (cnt_q == '0) begin
                    st_d  = PH_LOW;
                    cnt_d = L_RAS;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            PH_LOW: begin
                if (cnt_q == '0) begin
                    if (self_i) begin
                        st_d  = PH_HOLD;
                        cnt_d = L_SELF;
                    end else begin
                        st_d  = PH_POST;
                        cnt_d = L_RP;
                    end
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            PH_HOLD: begin
                if (cnt_q != '0) begin
                    cnt_d = cnt_q - ONE;
                end else if (wake_i) begin
                    st_d  = PH_POST;
                    cnt_d = L_RPS;
                end
            end
            PH_POST: begin
                if (cnt_q == '0) begin
                    st_d = PH_IDLE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            default: begin
                st_d  = PH_IDLE;
                cnt_d = '0;
            end
        endcase
    end

    // Strobe levels for the phase being entered.
    always_comb begin
        ras_d = !((st_d == PH_LOW) || (st_d == PH_HOLD));
        cas_d = !((st_d == PH_CSR) || ((st_d == PH_LOW) && (cnt_d >= CAS_REL)));
    end

    // State and strobe registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PH_IDLE;
            cnt_q <= '0;
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ras_q <= ras_d;
            cas_q <= cas_d;
        end
    end

    assign ras_n_o = ras_q;
    assign cas_n_o = cas_q;
    assign busy_o  = (st_q != PH_IDLE);
    assign done_o  = (st_q == PH_POST) && (cnt_q == '0);

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_q) |-> !cas_q);                                   // R3
    AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_IDLE) |-> (ras_q && cas_q));                    // R12
    AST_HOLD_ONLY_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PH_HOLD) |-> self_i);                              // R10

endmodule

// File: rtl/cbr_debt_timer.sv
// Module: cbr_debt_timer
// Counts refresh intervals and keeps the number of owed refreshes.
// Flags urgency at the limit and a loss when an interval expires
// with the limit already reached. Assumes pay_i only while owed.
module cbr_debt_timer #(
    parameter int INTERVAL_CYC = 1560,
    parameter int DEBT_MAX     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clear_i,
    input  logic pay_i,
    output logic pending_o,
    output logic urgent_o,
    output logic lost_o
);

    localparam int IW = $clog2(INTERVAL_CYC + 1);
    localparam int DW = $clog2(DEBT_MAX + 1);
    localparam logic [IW-1:0] I_LAST   = IW'(INTERVAL_CYC - 1);
    localparam logic [DW-1:0] DEBT_TOP = DW'(DEBT_MAX);

    logic [IW-1:0] tcnt_q;
    logic [DW-1:0] debt_q;
    logic          tick;

    assign tick   = run_i && (tcnt_q == I_LAST);
    assign lost_o = tick && !pay_i && (debt_q == DEBT_TOP);

    // Interval counter.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            tcnt_q <= '0;
        end else if (run_i) begin
            tcnt_q <= tick ? '0 : tcnt_q + IW'(1);
        end
    end

    // Owed-refresh counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            debt_q <= '0;
        end else if (tick && !pay_i && (debt_q != DEBT_TOP)) begin
            debt_q <= debt_q + DW'(1);
        end else if (pay_i && !tick) begin
            debt_q <= debt_q - DW'(1);
        end
    end

    assign pending_o = (debt_q != '0);
    assign urgent_o  = (debt_q == DEBT_TOP);

    AST_DEBT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        debt_q <= DEBT_TOP);                                        // R8
    AST_PAY_OWED: assert property (@(posedge clk) disable iff (!rst_n)
        pay_i |-> (debt_q != '0));                                  // R7

endmodule

// File: rtl/cbr_refresh_sched.sv
// Module: cbr_refresh_sched (top)
// Power-up pause, wake-up refresh train, granted periodic refresh
// with postponement, loss recovery, and self refresh on command.
// Assumes the sequencer raises grant_i only while it drives no
// strobe, and starts no access while busy_o or !init_done_o.
module cbr_refresh_sched
    import cbr_sched_pkg::*;
#(
    parameter int PWRUP_CYC    = 10000,
    parameter int INIT_CYCLES  = 8,
    parameter int INTERVAL_CYC = 1560,
    parameter int DEBT_MAX     = 4,
    parameter int RP_CYC       = 4,
    parameter int CSR_CYC      = 1,
    parameter int RAS_CYC      = 6,
    parameter int CHR_CYC      = 1,
    parameter int SELF_CYC     = 10000,
    parameter int RPS_CYC      = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant_i,
    input  logic sleep_i,
    input  logic wake_i,
    output logic req_o,
    output logic urgent_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic we_n_o,
    output logic busy_o,
    output logic init_done_o
);

    localparam int PW = $clog2(PWRUP_CYC + 1);
    localparam int NW = $clog2(INIT_CYCLES + 1);
    localparam logic [PW-1:0] P_LAST = PW'(PWRUP_CYC - 1);
    localparam logic [NW-1:0] INIT_N = NW'(INIT_CYCLES);

    mode_e          mode_q, mode_d;
    logic [PW-1:0]  pcnt_q, pcnt_d;
    logic [NW-1:0]  icnt_q, icnt_d;
    logic           init_done_q, init_done_d;
    logic           lost_q, lost_d;
    logic           eng_start, eng_self, eng_busy, eng_done;
    logic           tm_run, tm_clear, tm_pay;
    logic           tm_pending, tm_urgent, tm_lost;
    logic           in_self;

    assign tm_run  = init_done_q && !lost_q && (mode_q != MD_SELF);
    assign in_self = (mode_q == MD_SELF);

    cbr_debt_timer #(
        .INTERVAL_CYC (INTERVAL_CYC),
        .DEBT_MAX     (DEBT_MAX)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (tm_run),
        .clear_i   (tm_clear),
        .pay_i     (tm_pay),
        .pending_o (tm_pending),
        .urgent_o  (tm_urgent),
        .lost_o    (tm_lost)
    );

    cbr_strobe_seq #(
        .RP_CYC   (RP_CYC),
        .CSR_CYC  (CSR_CYC),
        .RAS_CYC  (RAS_CYC),
        .CHR_CYC  (CHR_CYC),
        .SELF_CYC (SELF_CYC),
        .RPS_CYC  (RPS_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (eng_start),
        .self_i  (eng_self),
        .wake_i  (wake_i),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .busy_o  (eng_busy),
        .done_o  (eng_done)
    );

    // Mode sequencing and arbitration against the access sequencer.
    always_comb begin
        mode_d      = mode_q;
        pcnt_d      = pcnt_q;
        icnt_d      = icnt_q;
        init_done_d = init_done_q;
        lost_d      = lost_q || tm_lost;
        eng_start   = 1'b0;
        eng_self    = 1'b0;
        tm_clear    = 1'b0;
        tm_pay      = 1'b0;
        unique case (mode_q)
            MD_PWR: begin
                if (pcnt_q == P_LAST) begin
                    mode_d = MD_INIT;
                    icnt_d = INIT_N;
                end else begin
                    pcnt_d = pcnt_q + PW'(1);
                end
            end
            MD_INIT: begin
                eng_start = !eng_busy && (icnt_q != '0);
                if (eng_done) begin
                    icnt_d = icnt_q - NW'(1);
                    if (icnt_q == NW'(1)) begin
                        mode_d      = MD_RUN;
                        init_done_d = 1'b1;
                        tm_clear    = 1'b1;
                    end
                end
            end
            MD_RUN: begin
                if (lost_q) begin
                    if (grant_i) begin
                        mode_d   = MD_INIT;
                        icnt_d   = INIT_N;
                        lost_d   = 1'b0;
                        tm_clear = 1'b1;
                    end
                end else if (grant_i && tm_pending && (tm_urgent || !sleep_i)) begin
                    eng_start = 1'b1;
                    mode_d    = MD_REF;
                end else if (grant_i && sleep_i) begin
                    eng_start = 1'b1;
                    eng_self  = 1'b1;
                    mode_d    = MD_SELF;
                end
            end
            MD_REF: begin
                if (eng_done) begin
                    tm_pay = 1'b1;
                    mode_d = MD_RUN;
                end
            end
            MD_SELF: begin
                eng_self = 1'b1;
                if (eng_done) begin
                    tm_clear = 1'b1;
                    mode_d   = MD_RUN;
                end
            end
            default: mode_d = MD_PWR;
        endcase
        if (tm_lost) begin
            init_done_d = 1'b0;
        end
    end

    // Mode, counters and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MD_PWR;
            pcnt_q      <= '0;
            icnt_q      <= '0;
            init_done_q <= 1'b0;
            lost_q      <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            pcnt_q      <= pcnt_d;
            icnt_q      <= icnt_d;
            init_done_q <= init_done_d;
            lost_q      <= lost_d;
        end
    end

    assign req_o       = tm_pending || lost_q;
    assign urgent_o    = tm_urgent || lost_q;
    assign we_n_o      = 1'b1;
    assign busy_o      = eng_busy;
    assign init_done_o = init_done_q;

    AST_GRANTED_START: assert property (@(posedge clk) disable iff (!rst_n)
        (init_done_q && $rose(eng_busy)) |-> $past(grant_i));       // R6
    AST_INIT_ENDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done_q) |-> !eng_busy);                          // R2
    AST_NO_DEBT_AFTER_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_self) |-> !req_o);                                 // R11
    AST_LOSS_DROPS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        lost_q |-> (!init_done_q && urgent_o));                     // R9

endmodule

// File: tb/cbr_refresh_sched_test.sv
// Directed bench for cbr_refresh_sched with short timing parameters.
module cbr_refresh_sched_test;

    localparam int PWRUP  = 200;
    localparam int INITN  = 8;
    localparam int INTV   = 100;
    localparam int DMAX   = 3;
    localparam int RP     = 4;
    localparam int CSR    = 1;
    localparam int RASW   = 6;
    localparam int CHR    = 2;
    localparam int SELFW  = 300;
    localparam int RPS    = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic grant = 1'b0, sleep = 1'b0, wake = 1'b0;
    logic req, urgent, ras_n, cas_n, we_n, busy, init_done;

    always #5 clk = ~clk;

    cbr_refresh_sched #(
        .PWRUP_CYC(PWRUP), .INIT_CYCLES(INITN), .INTERVAL_CYC(INTV),
        .DEBT_MAX(DMAX), .RP_CYC(RP), .CSR_CYC(CSR), .RAS_CYC(RASW),
        .CHR_CYC(CHR), .SELF_CYC(SELFW), .RPS_CYC(RPS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .grant_i(grant), .sleep_i(sleep),
        .wake_i(wake), .req_o(req), .urgent_o(urgent), .ras_n_o(ras_n),
        .cas_n_o(cas_n), .we_n_o(we_n), .busy_o(busy), .init_done_o(init_done)
    );

    int n_chk = 0, n_fail = 0;
    int cyc = 0, rel_cyc = 0, first_cas = -1;
    int cbr_cnt = 0, ras_low_run = 0, ras_high_run = 1000, cas_low_run = 0;
    int last_low_len = 0, exit_high = 0, grant_rise = 0;
    int v_csr = 0, v_we = 0, v_ras = 0, v_chr = 0, v_rp = 0, v_pre = 0, v_idle = 0;
    logic pr_ras = 1'b1, pr_cas = 1'b1, pr_busy = 1'b0, pr_grant = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Strobe timing monitor, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!we_n) v_we++;
            if (!busy && (!ras_n || !cas_n)) v_idle++;
            if (grant && !pr_grant) grant_rise = cyc;
            if (pr_cas && !cas_n) begin
                if (first_cas < 0) first_cas = cyc;
                if (init_done && (cyc - grant_rise) < RP) v_pre++;
            end
            if (pr_ras && !ras_n) begin
                cbr_cnt++;
                if (cas_n || cas_low_run < CSR) v_csr++;
                if (ras_high_run < RP) v_rp++;
            end
            if (!pr_ras && ras_n) begin
                last_low_len = ras_low_run;
                if (ras_low_run < RASW) v_ras++;
            end
            if (!pr_cas && cas_n && !ras_n && ras_low_run < CHR) v_chr++;
            if (pr_busy && !busy) exit_high = ras_high_run;
            ras_low_run  = !ras_n ? ras_low_run + 1 : 0;
            ras_high_run =  ras_n ? ras_high_run + 1 : 0;
            cas_low_run  = !cas_n ? cas_low_run + 1 : 0;
            pr_ras = ras_n; pr_cas = cas_n; pr_busy = busy; pr_grant = grant;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drive(input logic g, input logic s, input logic w);
        @(posedge clk); #1;
        grant = g; sleep = s; wake = w;
    endtask

    task automatic t_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes in reset", {ras_n, cas_n, we_n}, 7);
        @(posedge clk); #1; rst_n = 1'b1; rel_cyc = cyc;
        @(negedge clk);
        chk(ras_n && cas_n && we_n, "R1 strobes after reset", {ras_n, cas_n, we_n}, 7);
        chk(!busy && !init_done && !req && !urgent, "R1 flags after reset",
            {busy, init_done, req, urgent}, 0);
    endtask

    task automatic t_powerup();
        for (int i = 0; i < 3000 && !init_done; i++) @(negedge clk);
        chk(init_done == 1'b1, "R2 init_done raised", init_done, 1);
        chk(first_cas - rel_cyc >= PWRUP, "R2 power-up pause", first_cas - rel_cyc, PWRUP);
        chk(cbr_cnt == INITN, "R2 wake-up cycle count", cbr_cnt, INITN);
    endtask

    task automatic t_periodic();
        int n = 0;
        int base;
        while (!req && n < 400) begin @(negedge clk); n++; end
        chk(n >= INTV - 2 && n <= INTV + 2, "R6 request interval", n, INTV);
        base = cbr_cnt;
        repeat (20) @(negedge clk);
        chk(cbr_cnt == base && req, "R6 no cycle without grant", cbr_cnt - base, 0);
        drive(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 50 && !busy; i++) @(negedge clk);
        for (int i = 0; i < 50 && busy; i++) @(negedge clk);
        drive(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk(cbr_cnt == base + 1, "R7 one refresh per debt", cbr_cnt - base, 1);
        chk(!req, "R7 request cleared", req, 0);
    endtask

    task automatic t_urgent();
        int base;
        for (int i = 0; i < 500 && !urgent; i++) @(negedge clk);
        chk(urgent && req && init_done, "R8 urgent at limit", {urgent, req, init_done}, 7);
        base = cbr_cnt;
        drive(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 200 && req; i++) @(negedge clk);
        drive(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk(cbr_cnt == base + DMAX, "R7 debt retired", cbr_cnt - base, DMAX);
        chk(!urgent && !req, "R8 urgent cleared", {urgent, req}, 0);
    endtask

    task automatic t_overflow();
        int base = cbr_cnt;
        for (int i = 0; i < 700 && init_done; i++) @(negedge clk);
        chk(!init_done && urgent && req, "R9 loss flagged", {init_done, urgent, req}, 3);
        chk(cbr_cnt == base, "R9 nothing before grant", cbr_cnt - base, 0);
        drive(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 500 && !init_done; i++) @(negedge clk);
        drive(1'b0, 1'b0, 1'b0);
        chk(cbr_cnt == base + INITN, "R9 wake-up repeated", cbr_cnt - base, INITN);
        chk(init_done == 1'b1, "R9 init_done again", init_done, 1);
    endtask

    task automatic t_self();
        int base = cbr_cnt;
        drive(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 20 && !busy; i++) @(negedge clk);
        drive(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 30 && ras_n; i++) @(negedge clk);
        repeat (SELFW + 30) @(negedge clk);
        chk(!ras_n && busy, "R10 RAS held until wake", ras_n, 0);
        chk(cbr_cnt == base + 1, "R10 single entry cycle", cbr_cnt - base, 1);
        drive(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 100 && busy; i++) @(negedge clk);
        drive(1'b0, 1'b0, 1'b0);
        chk(last_low_len >= SELFW + 30, "R10 hold length", last_low_len, SELFW + 30);
        chk(exit_high >= RPS, "R11 exit precharge", exit_high, RPS);
        chk(!req, "R11 no debt on exit", req, 0);
        repeat (INTV - 10) @(negedge clk);
        chk(!req, "R11 no burst after exit", req, 0);
    endtask

    task automatic t_audit();
        chk(v_csr == 0, "R3 CAS setup before RAS", v_csr, 0);
        chk(v_we == 0, "R3 WE held high", v_we, 0);
        chk(v_ras == 0, "R4 RAS low width", v_ras, 0);
        chk(v_chr == 0, "R4 CAS hold", v_chr, 0);
        chk(v_rp == 0, "R5 RAS precharge", v_rp, 0);
        chk(v_pre == 0, "R5 precharge after grant", v_pre, 0);
        chk(v_idle == 0, "R12 strobes idle when not busy", v_idle, 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_periodic();
        t_urgent();
        t_overflow();
        t_self();
        t_audit();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule